// File: doc/BRIEF.md
# Queue-Port Messaging Unit

This block is the mailbox between a host bus slave port and a local processor. The host sees a small word-addressed register window. It holds two inbound and two outbound message words, an inbound doorbell, and a status/mask pair for each direction. It also holds two queue ports. On the inbound port, a read takes a free request handle from a pool and a write posts a filled request. On the outbound port, a read takes a completed handle and a write gives a handle back to the free pool. The local processor uses a second port of the same shape. Through it the local side seeds the pool, drains posted requests, pushes completions and answers messages.

A handle with its top bit clear is an offset into device memory. A handle with its top bit set names a host buffer: its low bits hold the buffer's bus address divided by 32. Handles and completion context words pass through the queues bit for bit. For the last request it drained, the local side can also read the decoded buffer address and the memory kind. Non-queued commands go through inbound message 0. The local side answers by writing the same word to outbound message 0, and that write raises the host interrupt.

Top module: `qport_msgunit`

## Requirements
- R1: After reset all message words, the doorbell, both status vectors and both mask vectors are zero, both interrupt outputs are low and all three queues are empty.
- R2: Every read request returns its data on the read-data output with the valid flag high in the cycle after the request. Host offsets: in-msg0 0x10, in-msg1 0x14, out-msg0 0x18, out-msg1 0x1C, doorbell 0x20, inbound status 0x24, inbound mask 0x28, outbound status 0x30, outbound mask 0x34, inbound port 0x40, outbound port 0x44. The local port uses the same offsets.
- R3: A host read of 0x40 removes and returns the oldest free handle. When the pool is empty it returns 0xFFFFFFFF and changes nothing.
- R4: A host write to 0x40 posts the word and sets inbound status bit 3. A local read of 0x40 drains posted words oldest first, or returns 0xFFFFFFFF when none is waiting.
- R5: Queued words are never altered. After each successful local drain, local offset 0x48 reads back bits 26..0 shifted left by 5 when bit 31 is set, and the word itself otherwise. Local offset 0x4C reads back bit 31 of that word in bit 0.
- R6: A local write to 0x44 queues any 32-bit completion word and sets outbound status bit 2. A host read of 0x44 drains completion words oldest first, or returns 0xFFFFFFFF when the queue is empty.
- R7: A host write to 0x44 and a local write to 0x40 both add a handle to the free pool. When both happen in one cycle, the host's handle is queued first.
- R8: A host write to in-msg0 or in-msg1 stores the word and sets inbound status bit 0 or 1. A local write to out-msg0 or out-msg1 stores the word and sets outbound status bit 0 or 1.
- R9: A host write to 0x20 ORs its bits into the doorbell and, if nonzero, sets inbound status bit 2. A local write to 0x20 clears the doorbell bits written as 1.
- R10: The host interrupt is the OR of the outbound status ANDed with the inverse of the outbound mask. The local interrupt is formed the same way from the inbound pair. Status bits are cleared by writing 1: the host writes 0x30, the local side writes 0x24. The host writes the outbound mask at 0x34 and the local side writes the inbound mask at 0x28. A set in the same cycle as a clear wins.
- R11: Each queue holds 16 entries. A push to a full queue is dropped, leaves the queue unchanged, and sets a sticky outbound status bit: bit 3 for completions, bit 4 for the free pool, bit 5 for posted requests.
- R12: Host writes to out-msg, inbound status, inbound mask or unmapped offsets change nothing. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host access strobe, one cycle per access |
| h_we | input | 1 | Host access is a write |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Host read data valid |
| h_rdata | output | 32 | Host read data |
| h_irq | output | 1 | Host interrupt |
| l_req | input | 1 | Local access strobe |
| l_we | input | 1 | Local access is a write |
| l_addr | input | 8 | Local byte offset |
| l_wdata | input | 32 | Local write data |
| l_rvalid | output | 1 | Local read data valid |
| l_rdata | output | 32 | Local read data |
| l_irq | output | 1 | Local interrupt |

## Verification
The assertions assume that each side issues at most one access per cycle and holds a strobe for one cycle only. They also assume that the host and local processor never pop the same queue, which the port map enforces. The random phase issues exactly one access per step. It picks its pushes without regard to queue fill, so drops do happen. The only simultaneous accesses are in the directed test of same-cycle pool writes.

// File: rtl/qpm_pkg.sv
package qpm_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned IST_W  = 4;
    localparam int unsigned OST_W  = 6;

    localparam logic [DATA_W-1:0] EMPTY_WORD = 32'hFFFF_FFFF;

    localparam logic [ADDR_W-1:0] OFF_IMSG0   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_IMSG1   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_OMSG0   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_OMSG1   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_DBELL   = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_ISTAT   = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_IMASK   = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_OSTAT   = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_OMASK   = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_INPORT  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_OUTPORT = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_DECADDR = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_DECKIND = 8'h4C;

    // inbound status bit positions
    localparam int unsigned IS_MSG0 = 0;
    localparam int unsigned IS_MSG1 = 1;
    localparam int unsigned IS_BELL = 2;
    localparam int unsigned IS_POST = 3;
    // outbound status bit positions
    localparam int unsigned OS_MSG0  = 0;
    localparam int unsigned OS_MSG1  = 1;
    localparam int unsigned OS_DONE  = 2;
    localparam int unsigned OS_DOVF  = 3;
    localparam int unsigned OS_FOVF  = 4;
    localparam int unsigned OS_POVF  = 5;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } acc_t;

    typedef struct packed {
        logic              host_mem;
        logic [DATA_W-1:0] addr;
    } handle_dec_t;

    function automatic acc_t mk_acc(logic req, logic we, logic [ADDR_W-1:0] a,
                                    logic [DATA_W-1:0] d);
        acc_t r;
        r.rd    = req & ~we;
        r.wr    = req & we;
        r.addr  = a;
        r.wdata = d;
        return r;
    endfunction

    function automatic handle_dec_t decode_handle(logic [DATA_W-1:0] h);
        handle_dec_t r;
        r.host_mem = h[DATA_W-1];
        r.addr     = h[DATA_W-1] ? {h[DATA_W-6:0], 5'b0_0000} : h;
        return r;
    endfunction

endpackage

// File: rtl/qpm_fifo.sv
module qpm_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_a,
    input  logic [W-1:0] data_a,
    input  logic         push_b,
    input  logic [W-1:0] data_b,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         drop_a,
    output logic         drop_b
);
    // DEPTH must be a power of two so pointers wrap naturally
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_b;
    logic [CW-1:0] count;
    logic [CW:0]   room;
    logic          pop_ok, acc_a, acc_b;

    always_comb begin
        pop_ok   = pop && (count != '0);
        room     = (CW+1)'(DEPTH) - {1'b0, count} + (CW+1)'(pop_ok);
        acc_a    = push_a && (room != '0);
        acc_b    = push_b && (room > (CW+1)'(acc_a));
        wr_ptr_b = acc_a ? wr_ptr + AW'(1) : wr_ptr;
    end

    assign drop_a = push_a & ~acc_a;
    assign drop_b = push_b & ~acc_b;
    assign empty  = (count == '0);
    assign head   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (acc_a) mem[wr_ptr]   <= data_a;
        if (acc_b) mem[wr_ptr_b] <= data_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(acc_a) + AW'(acc_b);
            rd_ptr <= rd_ptr + AW'(pop_ok);
            count  <= count + CW'(acc_a) + CW'(acc_b) - CW'(pop_ok);
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)) else $error("fifo count over depth"); // R11
    AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        drop_a |-> (count == CW'(DEPTH) && !pop)) else $error("drop while room"); // R11
    AST_EMPTY_POP_STABLE: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push_a && !push_b) |=> empty) else $error("empty pop moved"); // R3

endmodule

// File: rtl/qpm_irq_bank.sv
module qpm_irq_bank #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= (status & ~clr) | set;
            if (mask_we) mask <= mask_wdata;
        end
    end

    assign irq = |(status & ~mask);

    AST_SET_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> ((status & $past(set)) == $past(set))) else $error("set lost"); // R10
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (|(clr & ~set)) |=> ((status & $past(clr & ~set)) == '0)) else $error("clear lost"); // R10
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(|set) || $past(mask_we))) else $error("irq without cause"); // R10

endmodule

// File: rtl/qport_msgunit.sv
module qport_msgunit
    import qpm_pkg::*;
#(
    parameter int unsigned POST_DEPTH = 16,
    parameter int unsigned FREE_DEPTH = 16,
    parameter int unsigned DONE_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_rvalid,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_irq,
    input  logic              l_req,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic              l_rvalid,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq
);
    acc_t ha, la;
    assign ha = mk_acc(h_req, h_we, h_addr, h_wdata);
    assign la = mk_acc(l_req, l_we, l_addr, l_wdata);

    // message words and doorbell
    logic [DATA_W-1:0] imsg0, imsg1, omsg0, omsg1, dbell;
    logic              h_imsg0_wr, h_imsg1_wr, l_omsg0_wr, l_omsg1_wr, h_bell_wr;

    assign h_imsg0_wr = ha.wr && ha.addr == OFF_IMSG0;
    assign h_imsg1_wr = ha.wr && ha.addr == OFF_IMSG1;
    assign l_omsg0_wr = la.wr && la.addr == OFF_OMSG0;
    assign l_omsg1_wr = la.wr && la.addr == OFF_OMSG1;
    assign h_bell_wr  = ha.wr && ha.addr == OFF_DBELL;

    always_ff @(posedge clk) begin
        if (rst) begin
            imsg0 <= '0;
            imsg1 <= '0;
            omsg0 <= '0;
            omsg1 <= '0;
            dbell <= '0;
        end else begin
            if (h_imsg0_wr) imsg0 <= ha.wdata;
            if (h_imsg1_wr) imsg1 <= ha.wdata;
            if (l_omsg0_wr) omsg0 <= la.wdata;
            if (l_omsg1_wr) omsg1 <= la.wdata;
            dbell <= (dbell & ~((la.wr && la.addr == OFF_DBELL) ? la.wdata : '0))
                   | (h_bell_wr ? ha.wdata : '0);
        end
    end

    // queues
    logic [DATA_W-1:0] free_head, post_head, done_head;
    logic free_empty, post_empty, done_empty;
    logic free_drop_h, free_drop_l, post_drop, post_drop_b, done_drop, done_drop_b;
    logic free_push_h, free_push_l, post_push, done_push;
    logic free_pop, post_pop, done_pop;

    assign free_push_h = ha.wr && ha.addr == OFF_OUTPORT;
    assign free_push_l = la.wr && la.addr == OFF_INPORT;
    assign free_pop    = ha.rd && ha.addr == OFF_INPORT;
    assign post_push   = ha.wr && ha.addr == OFF_INPORT;
    assign post_pop    = la.rd && la.addr == OFF_INPORT;
    assign done_push   = la.wr && la.addr == OFF_OUTPORT;
    assign done_pop    = ha.rd && ha.addr == OFF_OUTPORT;

    qpm_fifo #(.DEPTH(FREE_DEPTH), .W(DATA_W)) u_free (
        .clk(clk), .rst(rst),
        .push_a(free_push_h), .data_a(ha.wdata),
        .push_b(free_push_l), .data_b(la.wdata),
        .pop(free_pop), .head(free_head), .empty(free_empty),
        .drop_a(free_drop_h), .drop_b(free_drop_l)
    );

    qpm_fifo #(.DEPTH(POST_DEPTH), .W(DATA_W)) u_post (
        .clk(clk), .rst(rst),
        .push_a(post_push), .data_a(ha.wdata),
        .push_b(1'b0), .data_b('0),
        .pop(post_pop), .head(post_head), .empty(post_empty),
        .drop_a(post_drop), .drop_b(post_drop_b)
    );

    qpm_fifo #(.DEPTH(DONE_DEPTH), .W(DATA_W)) u_done (
        .clk(clk), .rst(rst),
        .push_a(done_push), .data_a(la.wdata),
        .push_b(1'b0), .data_b('0),
        .pop(done_pop), .head(done_head), .empty(done_empty),
        .drop_a(done_drop), .drop_b(done_drop_b)
    );

    // decoded view of the last drained request
    handle_dec_t last_dec;
    always_ff @(posedge clk) begin
        if (rst) last_dec <= '0;
        else if (post_pop && !post_empty) last_dec <= decode_handle(post_head);
    end

    // status banks
    logic [IST_W-1:0] ist_set, ist, imask;
    logic [OST_W-1:0] ost_set, ost, omask;

    always_comb begin
        ist_set          = '0;
        ist_set[IS_MSG0] = h_imsg0_wr;
        ist_set[IS_MSG1] = h_imsg1_wr;
        ist_set[IS_BELL] = h_bell_wr && (ha.wdata != '0);
        ist_set[IS_POST] = post_push && !post_drop;
        ost_set          = '0;
        ost_set[OS_MSG0] = l_omsg0_wr;
        ost_set[OS_MSG1] = l_omsg1_wr;
        ost_set[OS_DONE] = done_push && !done_drop;
        ost_set[OS_DOVF] = done_drop | done_drop_b;
        ost_set[OS_FOVF] = free_drop_h | free_drop_l;
        ost_set[OS_POVF] = post_drop | post_drop_b;
    end

    qpm_irq_bank #(.W(IST_W)) u_in_irq (
        .clk(clk), .rst(rst),
        .set(ist_set),
        .clr((la.wr && la.addr == OFF_ISTAT) ? la.wdata[IST_W-1:0] : '0),
        .mask_we(la.wr && la.addr == OFF_IMASK),
        .mask_wdata(la.wdata[IST_W-1:0]),
        .status(ist), .mask(imask), .irq(l_irq)
    );

    qpm_irq_bank #(.W(OST_W)) u_out_irq (
        .clk(clk), .rst(rst),
        .set(ost_set),
        .clr((ha.wr && ha.addr == OFF_OSTAT) ? ha.wdata[OST_W-1:0] : '0),
        .mask_we(ha.wr && ha.addr == OFF_OMASK),
        .mask_wdata(ha.wdata[OST_W-1:0]),
        .status(ost), .mask(omask), .irq(h_irq)
    );

    // read muxes
    logic [DATA_W-1:0] h_mux, l_mux;

    always_comb begin
        case (ha.addr)
            OFF_IMSG0:   h_mux = imsg0;
            OFF_IMSG1:   h_mux = imsg1;
            OFF_OMSG0:   h_mux = omsg0;
            OFF_OMSG1:   h_mux = omsg1;
            OFF_DBELL:   h_mux = dbell;
            OFF_ISTAT:   h_mux = DATA_W'(ist);
            OFF_IMASK:   h_mux = DATA_W'(imask);
            OFF_OSTAT:   h_mux = DATA_W'(ost);
            OFF_OMASK:   h_mux = DATA_W'(omask);
            OFF_INPORT:  h_mux = free_empty ? EMPTY_WORD : free_head;
            OFF_OUTPORT: h_mux = done_empty ? EMPTY_WORD : done_head;
            default:     h_mux = '0;
        endcase
    end

    always_comb begin
        case (la.addr)
            OFF_IMSG0:   l_mux = imsg0;
            OFF_IMSG1:   l_mux = imsg1;
            OFF_OMSG0:   l_mux = omsg0;
            OFF_OMSG1:   l_mux = omsg1;
            OFF_DBELL:   l_mux = dbell;
            OFF_ISTAT:   l_mux = DATA_W'(ist);
            OFF_IMASK:   l_mux = DATA_W'(imask);
            OFF_OSTAT:   l_mux = DATA_W'(ost);
            OFF_OMASK:   l_mux = DATA_W'(omask);
            OFF_INPORT:  l_mux = post_empty ? EMPTY_WORD : post_head;
            OFF_DECADDR: l_mux = last_dec.addr;
            OFF_DECKIND: l_mux = DATA_W'(last_dec.host_mem);
            default:     l_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_rvalid <= 1'b0;
            h_rdata  <= '0;
            l_rvalid <= 1'b0;
            l_rdata  <= '0;
        end else begin
            h_rvalid <= ha.rd;
            l_rvalid <= la.rd;
            if (ha.rd) h_rdata <= h_mux;
            if (la.rd) l_rdata <= l_mux;
        end
    end

    AST_HOST_RVALID: assert property (@(posedge clk) disable iff (rst)
        (h_req && !h_we) |=> h_rvalid) else $error("host read not answered"); // R2
    AST_LOCAL_RVALID: assert property (@(posedge clk) disable iff (rst)
        !(l_req && !l_we) |=> !l_rvalid) else $error("spurious local valid"); // R2
    AST_EMPTY_POOL_WORD: assert property (@(posedge clk) disable iff (rst)
        (free_pop && free_empty) |=> (h_rdata == EMPTY_WORD)) else $error("empty pool word"); // R3
    AST_BELL_STICKY: assert property (@(posedge clk) disable iff (rst)
        h_bell_wr |=> ((dbell & $past(h_wdata)) == $past(h_wdata))) else $error("bell lost"); // R9
    AST_DONE_RAISES: assert property (@(posedge clk) disable iff (rst)
        (done_push && !done_drop) |=> ost[OS_DONE]) else $error("completion not flagged"); // R6

endmodule

// File: tb/qport_msgunit_tb.sv
module qport_msgunit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_req = 1'b0, h_we = 1'b0, l_req = 1'b0, l_we = 1'b0;
    logic [7:0]  h_addr = '0, l_addr = '0;
    logic [31:0] h_wdata = '0, l_wdata = '0;
    logic        h_rvalid, l_rvalid, h_irq, l_irq;
    logic [31:0] h_rdata, l_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    qport_msgunit u_dut (
        .clk(clk), .rst(rst),
        .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rvalid(h_rvalid), .h_rdata(h_rdata), .h_irq(h_irq),
        .l_req(l_req), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rvalid(l_rvalid), .l_rdata(l_rdata), .l_irq(l_irq)
    );

    logic [31:0] free_q[$];
    logic [31:0] post_q[$];
    logic [31:0] done_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_decode(input logic [31:0] h);
        if (h[31]) return (h & 32'h07FF_FFFF) << 5;
        return h;
    endfunction

    // all tasks start and end just after a falling edge
    task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
        h_req = 1; h_we = 1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_req = 0; h_we = 0;
    endtask

    task automatic loc_wr(input logic [7:0] a, input logic [31:0] d);
        l_req = 1; l_we = 1; l_addr = a; l_wdata = d;
        @(negedge clk);
        l_req = 0; l_we = 0;
    endtask

    task automatic both_wr(input logic [7:0] ha_, input logic [31:0] hd,
                           input logic [7:0] la_, input logic [31:0] ld);
        h_req = 1; h_we = 1; h_addr = ha_; h_wdata = hd;
        l_req = 1; l_we = 1; l_addr = la_; l_wdata = ld;
        @(negedge clk);
        h_req = 0; h_we = 0; l_req = 0; l_we = 0;
    endtask

    task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
        h_req = 1; h_we = 0; h_addr = a;
        @(negedge clk);
        h_req = 0;
        chk("R2 host rvalid", 32'(h_rvalid), 32'd1);
        d = h_rdata;
    endtask

    task automatic loc_rd(input logic [7:0] a, output logic [31:0] d);
        l_req = 1; l_we = 0; l_addr = a;
        @(negedge clk);
        l_req = 0;
        chk("R2 local rvalid", 32'(l_rvalid), 32'd1);
        d = l_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20517));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 h_irq", 32'(h_irq), 0);
        chk("R1 l_irq", 32'(l_irq), 0);
        chk("R1 rvalid idle", 32'(h_rvalid), 0);
        host_rd(8'h30, d); chk("R1 out status", d, 0);
        host_rd(8'h34, d); chk("R1 out mask", d, 0);
        loc_rd(8'h24, d);  chk("R1 in status", d, 0);
        loc_rd(8'h10, d);  chk("R1 in msg0", d, 0);
        host_rd(8'h40, d); chk("R3 empty pool", d, 32'hFFFF_FFFF);
        host_rd(8'h44, d); chk("R6 empty done", d, 32'hFFFF_FFFF);
        loc_rd(8'h40, d);  chk("R4 empty post", d, 32'hFFFF_FFFF);

        // R8 message echo, R10 irq
        host_wr(8'h10, 32'hA5A5_0001);
        loc_rd(8'h10, d);  chk("R8 in msg0 seen", d, 32'hA5A5_0001);
        loc_rd(8'h24, d);  chk("R8 in status bit0", d, 32'h1);
        chk("R10 l_irq on msg", 32'(l_irq), 1);
        loc_wr(8'h18, 32'hA5A5_0001);
        host_rd(8'h18, d); chk("R8 out msg0 echo", d, 32'hA5A5_0001);
        host_rd(8'h30, d); chk("R8 out status bit0", d, 32'h1);
        chk("R10 h_irq on echo", 32'(h_irq), 1);
        host_wr(8'h30, 32'h1);
        chk("R10 h_irq cleared", 32'(h_irq), 0);
        host_wr(8'h14, 32'h0000_0777);
        loc_rd(8'h24, d);  chk("R8 in status bit1", d, 32'h3);
        loc_wr(8'h1C, 32'h0000_0888);
        host_rd(8'h1C, d); chk("R8 out msg1", d, 32'h888);
        host_rd(8'h30, d); chk("R8 out status bit1", d, 32'h2);
        host_wr(8'h30, 32'h3F);
        loc_wr(8'h24, 32'hF);
        chk("R10 l_irq cleared", 32'(l_irq), 0);

        // R10 mask
        host_wr(8'h34, 32'h3F);
        loc_wr(8'h18, 32'h0000_0042);
        chk("R10 masked h_irq", 32'(h_irq), 0);
        host_rd(8'h30, d); chk("R10 status under mask", d, 32'h1);
        host_wr(8'h34, 32'h0);
        chk("R10 unmasked h_irq", 32'(h_irq), 1);
        host_wr(8'h30, 32'h1);
        loc_wr(8'h28, 32'hF);
        host_wr(8'h10, 32'h1);
        chk("R10 local masked", 32'(l_irq), 0);
        loc_wr(8'h28, 32'h0);
        chk("R10 local unmasked", 32'(l_irq), 1);
        loc_wr(8'h24, 32'hF);

        // R9 doorbell
        host_wr(8'h20, 32'h5);
        host_wr(8'h20, 32'h2);
        loc_rd(8'h20, d);  chk("R9 doorbell or", d, 32'h7);
        loc_rd(8'h24, d);  chk("R9 bell status", d, 32'h4);
        loc_wr(8'h20, 32'h1);
        loc_rd(8'h20, d);  chk("R9 doorbell w1c", d, 32'h6);
        loc_wr(8'h20, 32'h6);
        loc_wr(8'h24, 32'hF);

        // R12 ignored writes
        host_wr(8'h18, 32'hDEAD_BEEF);
        host_wr(8'h28, 32'hF);
        host_wr(8'h60, 32'h1234_5678);
        host_rd(8'h18, d); chk("R12 out msg kept", d, 32'h42);
        loc_rd(8'h28, d);  chk("R12 in mask kept", d, 0);
        host_rd(8'h60, d); chk("R12 unmapped zero", d, 0);

        // R3 / R7 free pool
        loc_wr(8'h40, 32'h0000_0100);
        loc_wr(8'h40, 32'h8000_1234);
        host_rd(8'h40, d); chk("R3 pool first", d, 32'h100);
        host_rd(8'h40, d); chk("R3 pool second", d, 32'h8000_1234);
        host_rd(8'h40, d); chk("R3 pool drained", d, 32'hFFFF_FFFF);
        both_wr(8'h44, 32'h0000_0A00, 8'h40, 32'h0000_0B00);
        host_rd(8'h40, d); chk("R7 host return first", d, 32'hA00);
        host_rd(8'h40, d); chk("R7 local seed second", d, 32'hB00);

        // R4 / R5 post and decode
        host_wr(8'h40, 32'h8000_0010);
        loc_rd(8'h24, d);  chk("R4 post status", d, 32'h8);
        loc_rd(8'h40, d);  chk("R5 host handle intact", d, 32'h8000_0010);
        loc_rd(8'h48, d);  chk("R5 host decode", d, exp_decode(32'h8000_0010));
        loc_rd(8'h4C, d);  chk("R5 host kind", d, 1);
        host_wr(8'h40, 32'h0000_0300);
        loc_rd(8'h40, d);  chk("R4 device handle", d, 32'h300);
        loc_rd(8'h48, d);  chk("R5 device decode", d, 32'h300);
        loc_rd(8'h4C, d);  chk("R5 device kind", d, 0);
        loc_rd(8'h40, d);  chk("R4 post empty", d, 32'hFFFF_FFFF);
        loc_rd(8'h48, d);  chk("R5 decode held", d, 32'h300);
        loc_wr(8'h24, 32'hF);

        // R6 completion
        host_wr(8'h30, 32'h3F);
        loc_wr(8'h44, 32'hCAFE_F00D);
        chk("R6 done irq", 32'(h_irq), 1);
        host_rd(8'h30, d); chk("R6 done status", d, 32'h4);
        host_rd(8'h44, d); chk("R6 context intact", d, 32'hCAFE_F00D);
        host_rd(8'h44, d); chk("R6 done drained", d, 32'hFFFF_FFFF);
        host_wr(8'h30, 32'h3F);

        // R11 overflow, each queue
        for (int i = 0; i < 17; i++) host_wr(8'h40, 32'h100 + 32'(i));
        host_rd(8'h30, d); chk("R11 post overflow bit", d, 32'h20);
        for (int i = 0; i < 16; i++) begin
            loc_rd(8'h40, d); chk("R11 post kept", d, 32'h100 + 32'(i));
        end
        loc_rd(8'h40, d);  chk("R11 post dropped", d, 32'hFFFF_FFFF);
        host_wr(8'h30, 32'h3F);
        for (int i = 0; i < 17; i++) loc_wr(8'h44, 32'h200 + 32'(i));
        host_rd(8'h30, d); chk("R11 done overflow bit", d, 32'h0C);
        for (int i = 0; i < 16; i++) begin
            host_rd(8'h44, d); chk("R11 done kept", d, 32'h200 + 32'(i));
        end
        host_rd(8'h44, d); chk("R11 done dropped", d, 32'hFFFF_FFFF);
        host_wr(8'h30, 32'h3F);
        for (int i = 0; i < 17; i++) loc_wr(8'h40, 32'h300 + 32'(i));
        host_rd(8'h30, d); chk("R11 free overflow bit", d, 32'h10);
        for (int i = 0; i < 16; i++) begin
            host_rd(8'h40, d); chk("R11 free kept", d, 32'h300 + 32'(i));
        end
        host_rd(8'h40, d); chk("R11 free dropped", d, 32'hFFFF_FFFF);
        host_wr(8'h30, 32'h3F);
        loc_wr(8'h24, 32'hF);

        // random traffic against queue models
        for (int it = 0; it < 400; it++) begin
            logic [31:0] v;
            int op;
            v  = $urandom;
            op = int'($urandom % 6);
            case (op)
                0: begin host_wr(8'h40, v); if (post_q.size() < 16) post_q.push_back(v); end
                1: begin
                    loc_rd(8'h40, d);
                    chk("R4 random post", d, post_q.size() ? post_q.pop_front() : 32'hFFFF_FFFF);
                end
                2: begin loc_wr(8'h44, v); if (done_q.size() < 16) done_q.push_back(v); end
                3: begin
                    host_rd(8'h44, d);
                    chk("R6 random done", d, done_q.size() ? done_q.pop_front() : 32'hFFFF_FFFF);
                end
                4: begin host_wr(8'h44, v); if (free_q.size() < 16) free_q.push_back(v); end
                default: begin
                    host_rd(8'h40, d);
                    chk("R7 random pool", d, free_q.size() ? free_q.pop_front() : 32'hFFFF_FFFF);
                end
            endcase
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule